// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block is an SMBus target that listens for the standard Host Notify message, which a device sends to a fixed host address. The message carries the 7-bit address of the notifying device in the upper bits of its first payload byte, then a 16-bit value sent low byte first. The block acknowledges each byte by pulling SDA low. When the message closes with a stop, the block publishes the captured values and sets a sticky status flag.

While that flag is set, the block refuses further notifications by leaving its own address byte unacknowledged. The values from the earlier notification therefore stay intact until software has read them and cleared the flag with a write-one-to-clear pulse. The flag raises either an ordinary interrupt output or a system-management output, chosen by a select input and gated by an enable input. SCL and SDA arrive already synchronized to `clk`. SDA is driven only through an open-drain style pull-down output.

Top module: `hnotify_rx`

## Requirements
- R1: With the status flag clear, a first byte of 0x10 after a start (address 0001000, bit 0 = 0 for write) is acknowledged: `sda_pull_o` is high during the ninth SCL high phase.
- R2: Any other first byte, including 0x11 (matching address with the read bit set), is not acknowledged, and nothing from that transfer is captured or flagged.
- R3: While the status flag is set, a first byte of 0x10 is not acknowledged, and the flag and the published address and data keep their values.
- R4: The published device address equals bits 7:1 of the second byte; bit 0 of that byte is discarded.
- R5: The third byte becomes the published low data byte and the fourth the high data byte; the second, third and fourth bytes are each acknowledged.
- R6: The status flag is set only by a stop that follows the acknowledge of the fourth byte; a stop or repeated start earlier in the message leaves the flag and the published values unchanged.
- R7: Published address and data change only when a notification completes; during reception they keep their previous values.
- R8: A one-cycle pulse on `sts_clr_i` clears the status flag; when the clear and a completing stop fall in the same cycle, the flag ends clear while the new values are still published.
- R9: `irq_o` equals flag AND `irq_en_i` AND NOT `smi_sel_i`, and `smi_o` equals flag AND `irq_en_i` AND `smi_sel_i`, each registered one clock after its inputs.
- R10: `sda_pull_o` changes only while SCL is low.
- R11: After reset the flag, both request outputs, `sda_pull_o` and all published values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level, as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| sts_clr_i | input | 1 | Write-one-to-clear pulse for the status flag |
| irq_en_i | input | 1 | Request enable |
| smi_sel_i | input | 1 | 1 routes the request to `smi_o` instead of `irq_o` |
| dev_addr_o | output | 7 | Published address of the notifying device |
| data_lo_o | output | 8 | Published low data byte |
| data_hi_o | output | 8 | Published high data byte |
| sts_o | output | 1 | Sticky notification status flag |
| irq_o | output | 1 | Interrupt request |
| smi_o | output | 1 | System-management request |

## Verification
The status flag can be set by a completing stop and cleared by software in the same clock. The bench provokes this by raising SDA to form the stop and, on the very next falling clock edge, pulsing `sts_clr_i`, so the clear lands in the cycle in which the internal completion pulse is registered. It then judges that the flag reads zero while the address and data of that notification have been published, and that a following notification is acknowledged, which shows that the flag really ended clear.

// File: rtl/hn_pkg.sv
package hn_pkg;

  // Target address of the Host Notify message (7-bit form)
  localparam logic [6:0] HOST_ADDR_DEF = 7'b0001000;

  // Receiver state
  typedef enum logic [2:0] {
    PS_IDLE,   // bus free or not addressed
    PS_RX,     // shifting in a byte
    PS_ACKW,   // byte taken, waiting for SCL low to drive ACK
    PS_ACKD,   // driving ACK, released on next SCL fall
    PS_DONE,   // all bytes acknowledged, waiting for stop
    PS_SKIP    // not for this block, wait for next start/stop
  } pst_e;

endpackage

// File: rtl/hn_busev.sv
module hn_busev (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);

  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  // SDA moving while SCL stays high marks start (falling) or stop (rising)
  assign start_o = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_o  = scl_i & scl_d & ~sda_d & sda_i;
  assign rise_o  = scl_i & ~scl_d;
  assign fall_o  = ~scl_i & scl_d;

endmodule

// File: rtl/hn_proto.sv
module hn_proto
  import hn_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter logic [6:0]  HOST_ADDR = HOST_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              busy_i,
  output logic              drv_o,
  output logic              commit_o,
  output logic [BYTE_W-2:0] sh_addr_o,
  output logic [BYTE_W-1:0] sh_lo_o,
  output logic [BYTE_W-1:0] sh_hi_o
);

  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int NBYTES = 4;
  localparam int BIDX_W = $clog2(NBYTES);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(NBYTES - 1);

  pst_e              st;
  logic [CNT_W-1:0]  cnt;
  logic [BIDX_W-1:0] bidx;
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] nb;

  assign nb = {sh, sda_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PS_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      sh        <= '0;
      drv_o     <= 1'b0;
      commit_o  <= 1'b0;
      sh_addr_o <= '0;
      sh_lo_o   <= '0;
      sh_hi_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      if (start_i) begin
        st    <= PS_RX;
        cnt   <= '0;
        bidx  <= '0;
        drv_o <= 1'b0;
      end else if (stop_i) begin
        if (st == PS_DONE) commit_o <= 1'b1;
        st    <= PS_IDLE;
        drv_o <= 1'b0;
      end else begin
        case (st)
          PS_RX: if (rise_i) begin
            sh  <= nb[BYTE_W-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              st <= PS_ACKW;
              case (bidx)
                2'd0: if (nb[BYTE_W-1:1] != HOST_ADDR || nb[0] || busy_i)
                        st <= PS_SKIP;
                2'd1: sh_addr_o <= nb[BYTE_W-1:1];
                2'd2: sh_lo_o   <= nb;
                default: sh_hi_o <= nb;
              endcase
            end
          end
          PS_ACKW: if (fall_i) begin
            drv_o <= 1'b1;
            st    <= PS_ACKD;
          end
          PS_ACKD: if (fall_i) begin
            drv_o <= 1'b0;
            cnt   <= '0;
            if (bidx == LAST_BYTE) begin
              st <= PS_DONE;
            end else begin
              bidx <= bidx + 1'b1;
              st   <= PS_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  commit_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> ($past(st) == PS_DONE));

endmodule

// File: rtl/hn_regs.sv
module hn_regs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [BYTE_W-2:0] sh_addr_i,
  input  logic [BYTE_W-1:0] sh_lo_i,
  input  logic [BYTE_W-1:0] sh_hi_i,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              sel_i,
  output logic [BYTE_W-2:0] addr_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              sts_o,
  output logic              irq_o,
  output logic              smi_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      lo_o   <= '0;
      hi_o   <= '0;
      sts_o  <= 1'b0;
      irq_o  <= 1'b0;
      smi_o  <= 1'b0;
    end else begin
      if (commit_i) begin
        addr_o <= sh_addr_i;
        lo_o   <= sh_lo_i;
        hi_o   <= sh_hi_i;
      end
      // clear wins over a same-cycle set
      if (clr_i)         sts_o <= 1'b0;
      else if (commit_i) sts_o <= 1'b1;
      irq_o <= sts_o & en_i & ~sel_i;
      smi_o <= sts_o & en_i & sel_i;
    end
  end

  // R6
  set_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !clr_i) |=> sts_o);
  // R8
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !sts_o);
  // R7
  hold_visible_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(addr_o) && $stable(lo_o) && $stable(hi_o)));
  // R3
  no_commit_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    commit_i |-> !sts_o);

endmodule

// File: rtl/hnotify_rx.sv
module hnotify_rx
  import hn_pkg::*;
#(
  parameter int         BYTE_W    = 8,
  parameter logic [6:0] HOST_ADDR = HOST_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              sts_clr_i,
  input  logic              irq_en_i,
  input  logic              smi_sel_i,
  output logic [BYTE_W-2:0] dev_addr_o,
  output logic [BYTE_W-1:0] data_lo_o,
  output logic [BYTE_W-1:0] data_hi_o,
  output logic              sts_o,
  output logic              irq_o,
  output logic              smi_o
);

  logic              start_w, stop_w, rise_w, fall_w;
  logic              commit_w;
  logic [BYTE_W-2:0] sh_addr_w;
  logic [BYTE_W-1:0] sh_lo_w, sh_hi_w;

  hn_busev u_busev (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  hn_proto #(.BYTE_W(BYTE_W), .HOST_ADDR(HOST_ADDR)) u_proto (
    .clk       (clk),
    .rst       (rst),
    .sda_i     (sda_i),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .busy_i    (sts_o),
    .drv_o     (sda_pull_o),
    .commit_o  (commit_w),
    .sh_addr_o (sh_addr_w),
    .sh_lo_o   (sh_lo_w),
    .sh_hi_o   (sh_hi_w)
  );

  hn_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit_w),
    .sh_addr_i (sh_addr_w),
    .sh_lo_i   (sh_lo_w),
    .sh_hi_i   (sh_hi_w),
    .clr_i     (sts_clr_i),
    .en_i      (irq_en_i),
    .sel_i     (smi_sel_i),
    .addr_o    (dev_addr_o),
    .lo_o      (data_lo_o),
    .hi_o      (data_hi_o),
    .sts_o     (sts_o),
    .irq_o     (irq_o),
    .smi_o     (smi_o)
  );

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull_o) || $fell(sda_pull_o)) |-> !scl_i);
  // R9
  one_request_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_o, smi_o}));

endmodule

// File: tb/hnotify_rx_test.sv
module hnotify_rx_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic clr = 1'b0, en = 1'b0, sel = 1'b0;
  logic sda_pull, sts, irq, smi, sda_bus;
  logic [6:0] dev;
  logic [7:0] lo, hi;

  assign sda_bus = sda_m & ~sda_pull;

  hnotify_rx uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .sts_clr_i(clr), .irq_en_i(en), .smi_sel_i(sel),
    .dev_addr_o(dev), .data_lo_o(lo), .data_hi_o(hi),
    .sts_o(sts), .irq_o(irq), .smi_o(smi)
  );

  typedef struct { string tag; logic [31:0] v; } item_t;
  item_t       exp_q[$];
  logic [31:0] obs_q[$];
  int total = 0, bad = 0, viol = 0;
  logic pull_prev = 1'b0;

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e;
      logic [31:0] o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      total++;
      if (o !== e.v) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", e.tag, o, e.v);
      end
    end
    if (!rst && sda_pull !== pull_prev && scl_m) viol++;
    pull_prev = sda_pull;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(string tag, logic [31:0] v, logic [31:0] o);
    item_t it;
    it.tag = tag;
    it.v   = v;
    exp_q.push_back(it);
    obs_q.push_back(o);
  endtask

  task automatic expect_regs(string tag, logic s, logic i, logic m,
                             logic [6:0] d, logic [7:0] h, logic [7:0] l);
    expect_val(tag, {6'd0, m, i, s, d, h, l}, {6'd0, smi, irq, sts, dev, hi, lo});
  endtask

  task automatic put_bit(logic b);
    sda_m = b; cyc(2);
    scl_m = 1'b1; cyc(4);
    scl_m = 1'b0; cyc(2);
  endtask

  task automatic send_byte(logic [7:0] b, logic acc, string tag);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; cyc(2);
    scl_m = 1'b1; cyc(2);
    expect_val(tag, {31'd0, ~acc}, {31'd0, sda_bus});
    cyc(2);
    scl_m = 1'b0; cyc(3);
  endtask

  task automatic start_c();
    sda_m = 1'b1; cyc(2);
    scl_m = 1'b1; cyc(2);
    sda_m = 1'b0; cyc(3);
    scl_m = 1'b0; cyc(2);
  endtask

  task automatic stop_c(logic with_clr);
    sda_m = 1'b0; cyc(2);
    scl_m = 1'b1; cyc(3);
    sda_m = 1'b1; cyc(1);
    if (with_clr) begin clr = 1'b1; cyc(1); clr = 1'b0; end
    cyc(5);
  endtask

  task automatic notify(logic [7:0] a, logic [7:0] d, logic [7:0] l,
                        logic [7:0] h, logic acc, string tag);
    start_c();
    send_byte(a, acc, {tag, " addr ack"});
    send_byte(d, acc, {tag, " dev ack"});
    send_byte(l, acc, {tag, " lo ack"});
    send_byte(h, acc, {tag, " hi ack"});
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(3);
    expect_regs("R11 reset regs", 0, 0, 0, 7'h00, 8'h00, 8'h00);
    expect_val("R11 reset pull", 0, {31'd0, sda_pull});

    en = 1'b1;
    // R1 R5: full message accepted
    notify(8'h10, 8'h54, 8'hA5, 8'h3C, 1'b1, "R1 R5 first");
    expect_regs("R7 R6 before stop", 0, 0, 0, 7'h00, 8'h00, 8'h00);
    stop_c(1'b0);
    expect_regs("R4 R5 R6 R9 published", 1, 1, 0, 7'h2A, 8'h3C, 8'hA5);

    // R3: busy refuses and keeps values
    notify(8'h10, 8'h10, 8'h11, 8'h22, 1'b0, "R3 busy");
    stop_c(1'b0);
    expect_regs("R3 values kept", 1, 1, 0, 7'h2A, 8'h3C, 8'hA5);

    // R9 routing
    sel = 1'b1; cyc(3);
    expect_regs("R9 smi route", 1, 0, 1, 7'h2A, 8'h3C, 8'hA5);
    en = 1'b0; cyc(3);
    expect_regs("R9 disabled", 1, 0, 0, 7'h2A, 8'h3C, 8'hA5);
    en = 1'b1; sel = 1'b0; cyc(3);

    // R8 plain clear
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(3);
    expect_regs("R8 clear", 0, 0, 0, 7'h2A, 8'h3C, 8'hA5);

    // R2 wrong address and read bit
    notify(8'h12, 8'h44, 8'h55, 8'h66, 1'b0, "R2 other addr");
    stop_c(1'b0);
    expect_regs("R2 other addr ignored", 0, 0, 0, 7'h2A, 8'h3C, 8'hA5);
    notify(8'h11, 8'h44, 8'h55, 8'h66, 1'b0, "R2 read bit");
    stop_c(1'b0);
    expect_regs("R2 read ignored", 0, 0, 0, 7'h2A, 8'h3C, 8'hA5);

    // R6 early stop
    start_c();
    send_byte(8'h10, 1'b1, "R6 short addr ack");
    send_byte(8'h77, 1'b1, "R6 short dev ack");
    stop_c(1'b0);
    expect_regs("R6 early stop", 0, 0, 0, 7'h2A, 8'h3C, 8'hA5);

    // R6 repeated start instead of stop
    notify(8'h10, 8'h66, 8'h01, 8'h02, 1'b1, "R6 restart");
    start_c();
    stop_c(1'b0);
    expect_regs("R6 restart no flag", 0, 0, 0, 7'h2A, 8'h3C, 8'hA5);

    // R4 odd LSB discarded
    notify(8'h10, 8'h9B, 8'h00, 8'hFF, 1'b1, "R4 odd");
    stop_c(1'b0);
    expect_regs("R4 lsb dropped", 1, 1, 0, 7'h4D, 8'hFF, 8'h00);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(3);

    // R8 R7 clear coincident with completing stop
    notify(8'h10, 8'h3E, 8'h5A, 8'hC3, 1'b1, "R8 coincide");
    stop_c(1'b1);
    expect_regs("R8 R7 clear wins, data published", 0, 0, 0, 7'h1F, 8'hC3, 8'h5A);
    notify(8'h10, 8'h20, 8'h0F, 8'hF0, 1'b1, "R8 after coincide");
    stop_c(1'b0);
    expect_regs("R8 next accepted", 1, 1, 0, 7'h10, 8'hF0, 8'h0F);

    expect_val("R10 pull moved with SCL high", 0, viol);
    cyc(5);
    if (exp_q.size() != 0 || obs_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard residue actual=%0d expected=0", exp_q.size() + obs_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule